// File: doc/BRIEF.md
# Embedded Message Length Extractor

This block monitors the byte stream arriving on a host-to-device (OUT) endpoint and pulls a 16-bit transfer length out of the payload itself. Software programs a byte offset measured from the first byte of the transfer. When the byte at that offset arrives, it is taken as the low length byte. The byte after it is taken as the high length byte. Both bytes land in the upper half of a 32-bit buffer-length value.

Two sticky flags show the progress of the capture. Once both flags are set, extraction stops until a new transfer begins. The position count runs only on valid bytes, so idle cycles and packet gaps do not disturb it. A length field can therefore straddle two packets. A one-cycle done pulse marks the completion of the capture. The lower half of the buffer-length value passes through unchanged from an input.

Top module: `msg_len_extract`

## Requirements
- R1: After reset, buf_len_o[31:16] is zero, lo_flag_o and hi_flag_o are 0, and done_o is 0.
- R2: A valid byte whose position since the start of the transfer equals offset_i is stored in buf_len_o[23:16] when capture is armed. lo_flag_o is set in the same update. Positions start at 0.
- R3: The next valid byte after the low byte, while armed, is stored in buf_len_o[31:24] and sets hi_flag_o. hi_flag_o is never set while lo_flag_o is clear.
- R4: With offset_i equal to 0, the byte that carries first_i is itself captured as the low length byte.
- R5: Only valid bytes advance the position. Cycles with valid_i low, including gaps between packets, leave the position and the capture unchanged.
- R6: Once both flags are set, further bytes do not modify buf_len_o[31:16] until a new transfer starts.
- R7: A valid byte with first_i high starts a new transfer. It clears both flags and resets that byte's position to 0. It does not clear the stored length bytes.
- R8: done_o is high for exactly one cycle, namely the cycle in which hi_flag_o first reads 1.
- R9: Capture is armed only when en_i and ep_out_i are both 1. Bytes arriving while capture is not armed are skipped but still advance the position.
- R10: buf_len_o[15:0] always equals base_len_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Extraction enable |
| ep_out_i | input | 1 | Endpoint is host-to-device (OUT) |
| offset_i | input | OFS_W | Byte position of the low length byte |
| valid_i | input | 1 | data_i carries a byte this cycle |
| first_i | input | 1 | This byte is the first of a transfer |
| data_i | input | 8 | Stream byte |
| base_len_i | input | 16 | Lower half of buffer-length value |
| buf_len_o | output | 32 | Buffer-length value with the extracted length in [31:16] |
| lo_flag_o | output | 1 | Low length byte captured (sticky) |
| hi_flag_o | output | 1 | High length byte captured (sticky) |
| done_o | output | 1 | One-cycle pulse when the high byte is captured |

## Verification
The main capture is exercised by a table of streams. The streams vary the offset, including 0 and positions deep in the stream, and place idle gaps before, between and after the two length bytes. These cases separate a position counter that counts valid bytes from one that counts cycles, and show whether the high byte is taken as the next valid byte rather than the next cycle. Each stream uses different byte values, so a swapped or shifted field shows up as a wrong value. Directed streams then test the following:
- trailing bytes after completion;
- a disabled enable and a non-OUT endpoint;
- an enable raised after the offset has already passed, which confirms the position kept running while capture was disabled;
- a restart that clears the flags while keeping the stored bytes.

// File: rtl/msg_len_extract_pkg.sv
package msg_len_extract_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2 * BYTE_W;
  localparam int REG_W  = 2 * LEN_W;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t hi;
    byte_t lo;
    logic  hi_flag;
    logic  lo_flag;
  } cap_state_t;
endpackage

// File: rtl/msg_len_pos_counter.sv
module msg_len_pos_counter #(
  parameter int OFS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             first_i,
  output logic [OFS_W-1:0] idx_o
);
  localparam logic [OFS_W-1:0] POS_MAX = '1;

  logic [OFS_W-1:0] pos_q;

  // position of the byte currently on the bus
  assign idx_o = first_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (valid_i) begin
      if (idx_o != POS_MAX) pos_q <= idx_o + 1'b1;
      else                  pos_q <= POS_MAX;
    end
  end
endmodule

// File: rtl/msg_len_capture.sv
module msg_len_capture
  import msg_len_extract_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       first_i,
  input  logic       armed_i,
  input  logic       hit_i,
  input  byte_t      data_i,
  output cap_state_t state_o,
  output logic       done_o
);
  cap_state_t st_q, st_d;
  logic       done_q, done_d;
  logic       lo_eff, hi_eff;

  // a new transfer drops the flags before this byte is judged
  assign lo_eff = first_i ? 1'b0 : st_q.lo_flag;
  assign hi_eff = first_i ? 1'b0 : st_q.hi_flag;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    if (valid_i) begin
      st_d.lo_flag = lo_eff;
      st_d.hi_flag = hi_eff;
      if (armed_i && !lo_eff && hit_i) begin
        st_d.lo      = data_i;
        st_d.lo_flag = 1'b1;
      end else if (armed_i && lo_eff && !hi_eff) begin
        st_d.hi      = data_i;
        st_d.hi_flag = 1'b1;
        done_d       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;
endmodule

// File: rtl/msg_len_extract.sv
module msg_len_extract
  import msg_len_extract_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ep_out_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic [7:0]       data_i,
  input  logic [15:0]      base_len_i,
  output logic [31:0]      buf_len_o,
  output logic             lo_flag_o,
  output logic             hi_flag_o,
  output logic             done_o
);
  logic [OFS_W-1:0] idx;
  logic             armed, hit;
  cap_state_t       cap;

  msg_len_pos_counter #(.OFS_W(OFS_W)) u_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .first_i (first_i),
    .idx_o   (idx)
  );

  assign armed = en_i && ep_out_i;
  assign hit   = (idx == offset_i);

  msg_len_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .first_i (first_i),
    .armed_i (armed),
    .hit_i   (hit),
    .data_i  (data_i),
    .state_o (cap),
    .done_o  (done_o)
  );

  assign buf_len_o = {cap.hi, cap.lo, base_len_i};
  assign lo_flag_o = cap.lo_flag;
  assign hi_flag_o = cap.hi_flag;
endmodule

// File: rtl/msg_len_extract_chk.sv
module msg_len_extract_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             ep_out_i,
  input logic [OFS_W-1:0] offset_i,
  input logic             valid_i,
  input logic             first_i,
  input logic [31:0]      buf_len_o,
  input logic             lo_flag_o,
  input logic             hi_flag_o,
  input logic             done_o
);
  p_hi_needs_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_flag_o |-> lo_flag_o);

  p_frozen_after_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_flag_o && !(valid_i && first_i)) |=> $stable(buf_len_o[31:16]));

  p_restart_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && first_i && offset_i != '0) |=> (!lo_flag_o && !hi_flag_o));

  p_done_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(hi_flag_o));

  p_rise_gives_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_flag_o) |-> done_o);

  p_idle_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(lo_flag_o) && $stable(hi_flag_o) && $stable(buf_len_o[31:16])));

  p_unarmed_no_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && ep_out_i) |=> !$rose(lo_flag_o) && !$rose(hi_flag_o));
endmodule

bind msg_len_extract msg_len_extract_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .ep_out_i  (ep_out_i),
  .offset_i  (offset_i),
  .valid_i   (valid_i),
  .first_i   (first_i),
  .buf_len_o (buf_len_o),
  .lo_flag_o (lo_flag_o),
  .hi_flag_o (hi_flag_o),
  .done_o    (done_o)
);

// File: tb/msg_len_extract_bench.sv
module msg_len_extract_bench;
  localparam int  OFS_W = 8;
  localparam time CLK_P = 20ns;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0, ep_out_i = 1'b0;
  logic [OFS_W-1:0] offset_i = '0;
  logic             valid_i = 1'b0, first_i = 1'b0;
  logic [7:0]       data_i = '0;
  logic [15:0]      base_len_i = 16'h1234;
  logic [31:0]      buf_len_o;
  logic             lo_flag_o, hi_flag_o, done_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  msg_len_extract #(.OFS_W(OFS_W)) u_msg_len_extract (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .ep_out_i(ep_out_i),
    .offset_i(offset_i), .valid_i(valid_i), .first_i(first_i), .data_i(data_i),
    .base_len_i(base_len_i), .buf_len_o(buf_len_o), .lo_flag_o(lo_flag_o),
    .hi_flag_o(hi_flag_o), .done_o(done_o)
  );

  // {offset, gap mask (gap after byte i), seed}
  localparam logic [23:0] VEC [6] = '{
    {8'd0, 8'b0000_0000, 8'h21},
    {8'd1, 8'b0000_0011, 8'h40},
    {8'd3, 8'b0000_1000, 8'h5a},
    {8'd2, 8'b0001_0100, 8'h77},
    {8'd5, 8'b1010_0101, 8'h90},
    {8'd6, 8'b0100_0000, 8'hc3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 3);
  endfunction

  task automatic send_byte(input logic [7:0] b, input logic f, inout int dones);
    valid_i = 1'b1; data_i = b; first_i = f;
    @(negedge clk);
    valid_i = 1'b0; first_i = 1'b0;
    if (done_o) dones++;
  endtask

  task automatic run_stream(input int ofs, input logic [7:0] gaps, input logic [7:0] seed,
                            input int n, output int dones);
    dones = 0;
    offset_i = OFS_W'(ofs);
    for (int i = 0; i < n; i++) begin
      send_byte(dbyte(seed, i), i == 0, dones);
      if (gaps[i%8]) begin
        @(negedge clk);
        if (done_o) dones++;
      end
    end
    @(negedge clk);
    if (done_o) dones++;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d;
    logic [15:0] keep;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 len", {16'h0, buf_len_o[31:16]}, 32'h0);
    chk("R1 flags", {30'h0, hi_flag_o, lo_flag_o}, 32'h0);
    chk("R1 done", {31'h0, done_o}, 32'h0);
    rst_ni = 1'b1;
    en_i = 1'b1; ep_out_i = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R8 R10
    for (int v = 0; v < 6; v++) begin
      int ofs;
      logic [7:0] gm, sd;
      ofs = int'(VEC[v][23:16]); gm = VEC[v][15:8]; sd = VEC[v][7:0];
      base_len_i = 16'h1000 + 16'(v);
      run_stream(ofs, gm, sd, 8, d);
      chk(ofs == 0 ? "R4 lo at offset 0" : "R2 lo byte", {24'h0, buf_len_o[23:16]},
          {24'h0, dbyte(sd, ofs)});
      chk("R3 hi byte (R5 gaps)", {24'h0, buf_len_o[31:24]}, {24'h0, dbyte(sd, ofs + 1)});
      chk("R2 R3 flags", {30'h0, hi_flag_o, lo_flag_o}, 32'h3);
      chk("R8 one done pulse", d, 1);
      chk("R10 low half", {16'h0, buf_len_o[15:0]}, {16'h0, 16'h1000 + 16'(v)});
    end

    // R6: trailing bytes after completion leave the fields alone
    keep = buf_len_o[31:16];
    d = 0;
    for (int i = 0; i < 3; i++) send_byte(8'hee - 8'(i), 1'b0, d);
    chk("R6 frozen", {16'h0, buf_len_o[31:16]}, {16'h0, keep});
    chk("R6 no extra done", d, 0);

    // R7: restart clears flags, keeps bytes
    offset_i = 8'd3;
    d = 0;
    send_byte(8'h11, 1'b1, d);
    chk("R7 flags cleared", {30'h0, hi_flag_o, lo_flag_o}, 32'h0);
    chk("R7 bytes kept", {16'h0, buf_len_o[31:16]}, {16'h0, keep});
    send_byte(8'h12, 1'b0, d); send_byte(8'h13, 1'b0, d);
    send_byte(8'h14, 1'b0, d);
    chk("R7 R2 lo after restart", {24'h0, buf_len_o[23:16]}, 32'h14);
    chk("R7 lo flag only", {30'h0, hi_flag_o, lo_flag_o}, 32'h1);
    send_byte(8'h15, 1'b0, d);
    chk("R8 done with hi", {31'h0, done_o}, 32'h1);
    @(negedge clk);
    chk("R8 done one cycle", {31'h0, done_o}, 32'h0);
    chk("R3 hi after restart", {24'h0, buf_len_o[31:24]}, 32'h15);

    // R9: disabled
    keep = buf_len_o[31:16];
    en_i = 1'b0;
    run_stream(1, 8'h00, 8'h60, 6, d);
    chk("R9 en low no flags", {30'h0, hi_flag_o, lo_flag_o}, 32'h0);
    chk("R9 en low fields", {16'h0, buf_len_o[31:16]}, {16'h0, keep});
    en_i = 1'b1; ep_out_i = 1'b0;
    run_stream(0, 8'h00, 8'h70, 6, d);
    chk("R9 not OUT no flags", {30'h0, hi_flag_o, lo_flag_o}, 32'h0);
    chk("R9 not OUT fields", {16'h0, buf_len_o[31:16]}, {16'h0, keep});
    chk("R9 no done", d, 0);

    // R9: position runs while disarmed; offset 1 passes before arming
    ep_out_i = 1'b1; en_i = 1'b0; offset_i = 8'd1;
    d = 0;
    send_byte(8'h81, 1'b1, d); send_byte(8'h82, 1'b0, d);
    en_i = 1'b1;
    send_byte(8'h83, 1'b0, d); send_byte(8'h84, 1'b0, d);
    chk("R9 R5 position kept running", {30'h0, hi_flag_o, lo_flag_o}, 32'h0);

    // R10 with a new base value
    base_len_i = 16'hbeef;
    @(negedge clk);
    chk("R10 passthrough", {16'h0, buf_len_o[15:0]}, 32'hbeef);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule